// File: doc/BRIEF.md
# Hierarchical Interrupt Controller

This block collects interrupt requests from four external pins, two internal critical sources, a group of internal main sources, a group of peripheral sources and a bank of DMA-engine sources, and sorts them into three classes: critical, main and peripheral. Each class has a fixed order within it, where the lowest-numbered active source wins. One encoded status word reports, for every class at once, whether it has a pending request and which source won. The CPU receives a critical output and a normal output. Software reads and writes six 32-bit registers through a simple select/write/address port.

The encoders are cascaded. Two critical or main codes are reserved, and they point software at the peripheral field. Peripheral source 0 stands for the whole DMA bank. That bank has its own pending and mask registers, so software finds the actual DMA channel by scanning the DMA pending register.

Register word addresses: 0 control, 1 peripheral mask, 2 main mask, 3 encoded status, 4 DMA pending, 5 DMA mask. Addresses 6 and 7 read as zero and ignore writes. A read returns data combinationally when select is high and write is low.

Top module: `irq_cascade_ctrl`

## Requirements
- R1: After reset the control register reads 0, the peripheral mask reads 0xFFFFFFFF, the main mask reads 0x0001FFFF, the DMA mask reads 0xFFFFFFFF, the DMA pending and encoded status registers read 0, and both interrupt outputs are 0.
- R2: External line n has a sense field at control bits [23-2n:22-2n]. Field 00 makes the request follow the pin (active high) and 11 makes it follow the inverted pin. In both level modes, writes to the line's clear bit have no effect.
- R3: Sense field 01 latches a request on a rising pin edge and field 10 on a falling edge. The request holds until a control write has a 1 in bit 27-n, and a 0 in that bit leaves it set. The opposite edge sets nothing.
- R4: An external request counts as active only when master enable bit 12 and the line enable are both 1. The line enable for line n is control bit 11-n.
- R5: External line 0 is critical source code 0. External lines 1, 2 and 3 are main source codes 1, 2 and 3.
- R6: mainIn[0] is main code 0 and mainIn[j] is main code j+4 for j from 1 to 12. Main code k is disabled by a 1 in main-mask bit 16-k. The main field reports the lowest active code in bits 20:16, with the flag in bit 21.
- R7: periphIn[k] is peripheral source k and is disabled by a 1 in peripheral-mask bit 31-k. The field reports the lowest active source in bits 28:24, with the flag in bit 29.
- R8: An active peripheral source numbered below PER_HI (default 4) raises critical code 2. Any other active peripheral source raises main code 4. The critical field sits in bits 9:8, with the flag in bit 10.
- R9: A high dmaReq bit sets its DMA pending bit. Writing 1 to a pending bit clears it. A 1 in the DMA mask disables the bit. Peripheral source 0 is active when any pending bit is unmasked.
- R10: critIn[0] and critIn[1] latch as critical codes 1 and 3. A status write with bit 10 set clears only the latch of the currently winning critical code. A status write with bit 10 clear does nothing.
- R11: irqCrit is 1 one cycle after the critical flag and control bit 0 are both 1. irqNorm is 1 one cycle after the main or peripheral flag is 1.
- R12: When a set and a clear reach the same request bit in one cycle, the set wins. This applies to the DMA pending bits, the critical latches and the edge latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Register access select |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 3 | Register word address |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, 0 when not reading |
| extPin | input | 4 | External interrupt pins |
| critIn | input | 2 | Internal critical request pulses |
| mainIn | input | 13 | Internal main sources, level |
| periphIn | input | NPER-1 | Peripheral sources 1 and up, level |
| dmaReq | input | DMA_N | DMA channel request pulses |
| irqCrit | output | 1 | Critical interrupt to CPU |
| irqNorm | output | 1 | Normal interrupt to CPU |

## Verification
The case that matters most is a new request arriving in the same cycle that software clears the same request bit. The bench provokes this twice. It raises a DMA request bit in the very cycle that a write-one-to-clear covers that bit. It also pulses a critical input in the cycle that a status acknowledge targets the same critical code. In both cases it reads back through the register port to confirm that the request survived and that the other bits cleared normally.

// File: rtl/irqh_pkg.sv
package irqh_pkg;
  localparam int EXT_N   = 4;
  localparam int MAIN_N  = 17;
  localparam int MAININ_W = MAIN_N - 4;
  localparam int CODE_W  = 5;

  typedef enum logic [2:0] {
    SEL_CTRL   = 3'd0,
    SEL_PMASK  = 3'd1,
    SEL_MMASK  = 3'd2,
    SEL_STATUS = 3'd3,
    SEL_DPEND  = 3'd4,
    SEL_DMASK  = 3'd5
  } regSel_e;

  typedef struct packed {
    logic wrCtrl;
    logic wrPMask;
    logic wrMMask;
    logic wrStatus;
    logic wrDPend;
    logic wrDMask;
    logic rdEn;
  } regStrobe_t;
endpackage

// File: rtl/irqh_prienc.sv
module irqh_prienc #(
  parameter int W  = 8,
  parameter int IW = 3
) (
  input  logic [W-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec[i]) idx = IW'(i);
    end
    any = |vec;
  end
endmodule

// File: rtl/irqh_regctl.sv
module irqh_regctl
  import irqh_pkg::*;
(
  input  logic       busSel,
  input  logic       busWr,
  input  logic [2:0] busAddr,
  output regStrobe_t strb,
  output regSel_e    rdSel
);
  always_comb begin
    strb = '0;
    rdSel = regSel_e'(busAddr);
    strb.rdEn = busSel & ~busWr;
    if (busSel && busWr) begin
      case (busAddr)
        3'd0: strb.wrCtrl = 1'b1;
        3'd1: strb.wrPMask = 1'b1;
        3'd2: strb.wrMMask = 1'b1;
        3'd3: strb.wrStatus = 1'b1;
        3'd4: strb.wrDPend = 1'b1;
        3'd5: strb.wrDMask = 1'b1;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/irqh_datapath.sv
module irqh_datapath
  import irqh_pkg::*;
#(
  parameter int NPER   = 24,
  parameter int PER_HI = 4,
  parameter int DMA_N  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  regStrobe_t          strb,
  input  regSel_e             rdSel,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [EXT_N-1:0]    extPin,
  input  logic [1:0]          critIn,
  input  logic [MAININ_W-1:0] mainIn,
  input  logic [NPER-1:1]     periphIn,
  input  logic [DMA_N-1:0]    dmaReq,
  output logic                irqCrit,
  output logic                irqNorm
);
  localparam logic [31:0] CTRL_WMASK = 32'h00FF_1F01;

  logic [31:0]       ctrlReg;
  logic [31:0]       perMask;
  logic [MAIN_N-1:0] mainMask;
  logic [DMA_N-1:0]  dmaPend, dmaMask;
  logic [EXT_N-1:0]  sync1, sync2, sync3, extReq, extPend;
  logic [1:0]        critLatch, ackClr;
  logic              dmaAny, perHi, perLo;
  logic [NPER-1:0]   perRaw, perActive;
  logic [MAIN_N-1:0] mainVec;
  logic [3:0]        critVec;
  logic              critPend, mainPend, perPend;
  logic [1:0]        critCode;
  logic [CODE_W-1:0] mainCode, perCode;
  logic [31:0]       statusWord;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      perMask  <= '1;
      mainMask <= '1;
      dmaMask  <= '1;
    end else begin
      if (strb.wrCtrl)  ctrlReg  <= busWdata & CTRL_WMASK;
      if (strb.wrPMask) perMask  <= busWdata;
      if (strb.wrMMask) mainMask <= busWdata[MAIN_N-1:0];
      if (strb.wrDMask) dmaMask  <= busWdata[DMA_N-1:0];
    end
  end

  // external lines: synchronizer and sense logic
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sync1 <= '0;
      sync2 <= '0;
      sync3 <= '0;
    end else begin
      sync1 <= extPin;
      sync2 <= sync1;
      sync3 <= sync2;
    end
  end

  for (genvar n = 0; n < EXT_N; n++) begin : g_ext
    logic [1:0] sense;
    logic       clrHit;
    assign sense  = ctrlReg[23-2*n -: 2];
    assign clrHit = strb.wrCtrl & busWdata[27-n];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) extReq[n] <= 1'b0;
      else begin
        case (sense)
          2'b00: extReq[n] <= sync2[n];
          2'b11: extReq[n] <= ~sync2[n];
          2'b01: extReq[n] <= (sync2[n] & ~sync3[n]) | (extReq[n] & ~clrHit);
          default: extReq[n] <= (~sync2[n] & sync3[n]) | (extReq[n] & ~clrHit);
        endcase
      end
    end
    assign extPend[n] = extReq[n] & ctrlReg[12] & ctrlReg[11-n];

    // R3
    edge_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      ((sense[0] ^ sense[1]) && extReq[n] && !strb.wrCtrl) |=> extReq[n]);
  end

  // DMA bank and critical latches
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dmaPend   <= '0;
      critLatch <= '0;
    end else begin
      dmaPend   <= dmaReq | (dmaPend & ~(strb.wrDPend ? busWdata[DMA_N-1:0] : '0));
      critLatch <= critIn | (critLatch & ~ackClr);
    end
  end
  assign dmaAny = |(dmaPend & ~dmaMask);

  // class source vectors
  always_comb begin
    perRaw = {periphIn, dmaAny};
    for (int k = 0; k < NPER; k++) perActive[k] = perRaw[k] & ~perMask[31-k];
    perHi = |perActive[PER_HI-1:0];
    perLo = |perActive[NPER-1:PER_HI];

    mainVec[0] = mainIn[0] & ~mainMask[16];
    for (int k = 1; k < 4; k++) mainVec[k] = extPend[k];
    mainVec[4] = perLo;
    for (int k = 5; k < MAIN_N; k++) mainVec[k] = mainIn[k-4] & ~mainMask[16-k];

    critVec = {critLatch[1], perHi, critLatch[0], extPend[0]};
  end

  irqh_prienc #(.W(4), .IW(2)) u_critEnc (.vec(critVec), .any(critPend), .idx(critCode));
  irqh_prienc #(.W(MAIN_N), .IW(CODE_W)) u_mainEnc (.vec(mainVec), .any(mainPend), .idx(mainCode));
  irqh_prienc #(.W(NPER), .IW(CODE_W)) u_perEnc (.vec(perActive), .any(perPend), .idx(perCode));

  always_comb begin
    ackClr[0] = strb.wrStatus & busWdata[10] & critPend & (critCode == 2'd1);
    ackClr[1] = strb.wrStatus & busWdata[10] & critPend & (critCode == 2'd3);
    statusWord = '0;
    statusWord[29]    = perPend;
    statusWord[28:24] = perCode;
    statusWord[21]    = mainPend;
    statusWord[20:16] = mainCode;
    statusWord[10]    = critPend;
    statusWord[9:8]   = critCode;
  end

  // CPU outputs
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irqCrit <= 1'b0;
      irqNorm <= 1'b0;
    end else begin
      irqCrit <= critPend & ctrlReg[0];
      irqNorm <= mainPend | perPend;
    end
  end

  // read mux
  always_comb begin
    busRdata = '0;
    if (strb.rdEn) begin
      case (rdSel)
        SEL_CTRL:   busRdata = ctrlReg;
        SEL_PMASK:  busRdata = perMask;
        SEL_MMASK:  busRdata = 32'(mainMask);
        SEL_STATUS: busRdata = statusWord;
        SEL_DPEND:  busRdata = 32'(dmaPend);
        SEL_DMASK:  busRdata = 32'(dmaMask);
        default:    busRdata = '0;
      endcase
    end
  end

  // R11
  crit_route_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ctrlReg[0] |=> !irqCrit);
  // R11
  norm_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(mainPend || perPend) |=> !irqNorm);
  // R9
  dma_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrDPend |=> ((dmaPend & $past(busWdata[DMA_N-1:0] & ~dmaReq)) == '0));
  // R8
  hi_redirect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (critPend && critCode == 2'd2) |-> (perPend && (32'(perCode) < PER_HI)));
  // R6
  main_mask_chk: assert property (@(posedge clk) disable iff (!rstN)
    (mainPend && (mainCode >= 5'd5 || mainCode == 5'd0)) |-> !mainMask[5'd16 - mainCode]);
endmodule

// File: rtl/irq_cascade_ctrl.sv
module irq_cascade_ctrl
  import irqh_pkg::*;
#(
  parameter int NPER   = 24,
  parameter int PER_HI = 4,
  parameter int DMA_N  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWr,
  input  logic [2:0]          busAddr,
  input  logic [31:0]         busWdata,
  output logic [31:0]         busRdata,
  input  logic [EXT_N-1:0]    extPin,
  input  logic [1:0]          critIn,
  input  logic [MAININ_W-1:0] mainIn,
  input  logic [NPER-1:1]     periphIn,
  input  logic [DMA_N-1:0]    dmaReq,
  output logic                irqCrit,
  output logic                irqNorm
);
  regStrobe_t strb;
  regSel_e    rdSel;

  irqh_regctl u_ctl (
    .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .strb(strb), .rdSel(rdSel)
  );

  irqh_datapath #(.NPER(NPER), .PER_HI(PER_HI), .DMA_N(DMA_N)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .rdSel(rdSel),
    .busWdata(busWdata), .busRdata(busRdata),
    .extPin(extPin), .critIn(critIn), .mainIn(mainIn),
    .periphIn(periphIn), .dmaReq(dmaReq),
    .irqCrit(irqCrit), .irqNorm(irqNorm)
  );
endmodule

// File: tb/sim_irq_cascade_ctrl.sv
module sim_irq_cascade_ctrl;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWr = 1'b0;
  logic [2:0]  busAddr = '0;
  logic [31:0] busWdata = '0, busRdata;
  logic [3:0]  extPin = '0;
  logic [1:0]  critIn = '0;
  logic [12:0] mainIn = '0;
  logic [23:1] periphIn = '0;
  logic [31:0] dmaReq = '0;
  logic        irqCrit, irqNorm;
  int checkCnt = 0, failCnt = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  irq_cascade_ctrl u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .extPin(extPin), .critIn(critIn),
    .mainIn(mainIn), .periphIn(periphIn), .dmaReq(dmaReq),
    .irqCrit(irqCrit), .irqNorm(irqNorm)
  );

  typedef struct packed {
    logic [31:0] ctrl;
    logic [31:0] pmask;
    logic [31:0] mmask;
    logic [31:0] dmask;
    logic [3:0]  pins;
    logic [12:0] main;
    logic [23:0] per;
    logic [31:0] dreq;
    logic [31:0] expStat;
    logic        expCrit;
    logic        expNorm;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0, 32'hFFFFFFFF, 32'h1FFFF, 32'hFFFFFFFF, 4'h0, 13'h0,    24'h0,      32'h0,  32'h00000000, 1'b0, 1'b0},
    '{32'h0, 32'hFFFFFFFF, 32'h0,     32'hFFFFFFFF, 4'h0, 13'h1004, 24'h0,      32'h0,  32'h00260000, 1'b0, 1'b1},
    '{32'h0, 32'hFFFFFFFF, 32'h400,   32'hFFFFFFFF, 4'h0, 13'h1004, 24'h0,      32'h0,  32'h00300000, 1'b0, 1'b1},
    '{32'h0, 32'h0,        32'h1FFFF, 32'hFFFFFFFF, 4'h0, 13'h0,    24'h008200, 32'h0,  32'h29240000, 1'b0, 1'b1},
    '{32'h1, 32'h0,        32'h1FFFF, 32'hFFFFFFFF, 4'h0, 13'h0,    24'h000204, 32'h0,  32'h22240600, 1'b1, 1'b1},
    '{32'h1, 32'h20000000, 32'h1FFFF, 32'hFFFFFFFF, 4'h0, 13'h0,    24'h000204, 32'h0,  32'h29240000, 1'b0, 1'b1},
    '{32'h000C1200, 32'hFFFFFFFF, 32'h1FFFF, 32'hFFFFFFFF, 4'hB, 13'h0, 24'h0,  32'h0,  32'h00220000, 1'b0, 1'b1},
    '{32'h000C0200, 32'hFFFFFFFF, 32'h1FFFF, 32'hFFFFFFFF, 4'hB, 13'h0, 24'h0,  32'h0,  32'h00000000, 1'b0, 1'b0},
    '{32'h00001801, 32'hFFFFFFFF, 32'h1FFFF, 32'hFFFFFFFF, 4'h1, 13'h0, 24'h0,  32'h0,  32'h00000400, 1'b1, 1'b0},
    '{32'h00001800, 32'hFFFFFFFF, 32'h1FFFF, 32'hFFFFFFFF, 4'h1, 13'h0, 24'h0,  32'h0,  32'h00000400, 1'b0, 1'b0},
    '{32'h0, 32'h0,        32'h1FFFF, 32'h0,        4'h0, 13'h0,    24'h0,      32'hA0, 32'h20000600, 1'b0, 1'b1},
    '{32'h0, 32'h0,        32'h1FFFF, 32'hA0,       4'h0, 13'h0,    24'h0,      32'hA0, 32'h00000000, 1'b0, 1'b0}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wrx(input logic [2:0] a, input logic [31:0] d,
                     input logic [31:0] dP, input logic [1:0] cP);
    logic [31:0] keepD;
    logic [1:0]  keepC;
    @(negedge clk);
    keepD = dmaReq; keepC = critIn;
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d;
    dmaReq = dmaReq | dP; critIn = critIn | cP;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0; busWdata = '0;
    dmaReq = keepD; critIn = keepC;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wrx(a, d, 32'h0, 2'b0);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("  %0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checkCnt++; failCnt++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    // R1 reset state
    rd(3'd0, rv); chk("R1 ctrl", rv, 32'h0);
    rd(3'd1, rv); chk("R1 pmask", rv, 32'hFFFFFFFF);
    rd(3'd2, rv); chk("R1 mmask", rv, 32'h0001FFFF);
    rd(3'd5, rv); chk("R1 dmask", rv, 32'hFFFFFFFF);
    rd(3'd4, rv); chk("R1 dpend", rv, 32'h0);
    rd(3'd3, rv); chk("R1 status", rv, 32'h0);
    chk("R1 outputs", {30'b0, irqCrit, irqNorm}, 32'h0);

    // table: R2 R4 R5 R6 R7 R8 R9 R11
    for (int i = 0; i < NV; i++) begin
      extPin = VECS[i].pins; mainIn = VECS[i].main;
      periphIn = VECS[i].per[23:1]; dmaReq = VECS[i].dreq;
      wr(3'd0, VECS[i].ctrl);
      wr(3'd1, VECS[i].pmask);
      wr(3'd2, VECS[i].mmask);
      wr(3'd5, VECS[i].dmask);
      wr(3'd4, 32'hFFFFFFFF);
      idle(8);
      rd(3'd3, rv);
      chk($sformatf("R6/R7/R8/R9 vector %0d status", i), rv, VECS[i].expStat);
      chk($sformatf("R11 vector %0d irqCrit", i), {31'b0, irqCrit}, {31'b0, VECS[i].expCrit});
      chk($sformatf("R11 vector %0d irqNorm", i), {31'b0, irqNorm}, {31'b0, VECS[i].expNorm});
    end
    dmaReq = '0;
    wr(3'd4, 32'hFFFFFFFF);
    wr(3'd5, 32'hFFFFFFFF);
    wr(3'd1, 32'hFFFFFFFF);
    idle(4);

    // R3 rising edge on line 1
    wr(3'd0, 32'h00101400); idle(4);
    extPin[1] = 1'b1; idle(6);
    rd(3'd3, rv); chk("R3 rise latched", rv, 32'h00210000);
    extPin[1] = 1'b0; idle(6);
    rd(3'd3, rv); chk("R3 held after pin drop", rv, 32'h00210000);
    wr(3'd0, 32'h00101400); idle(3);
    rd(3'd3, rv); chk("R3 zero clear bit no effect", rv, 32'h00210000);
    wr(3'd0, 32'h04101400); idle(3);
    rd(3'd3, rv); chk("R3 cleared", rv, 32'h0);

    // R3 falling edge on line 3
    wr(3'd0, 32'h00021100); idle(4);
    extPin[3] = 1'b1; idle(6);
    rd(3'd3, rv); chk("R3 rise ignored in falling mode", rv, 32'h0);
    extPin[3] = 1'b0; idle(6);
    rd(3'd3, rv); chk("R3 fall latched", rv, 32'h00230000);
    wr(3'd0, 32'h01021100); idle(3);
    rd(3'd3, rv); chk("R3 fall cleared", rv, 32'h0);

    // R2 level mode ignores clear
    wr(3'd0, 32'h00001200);
    extPin[2] = 1'b1; idle(6);
    rd(3'd3, rv); chk("R2 level high", rv, 32'h00220000);
    wr(3'd0, 32'h02001200); idle(3);
    rd(3'd3, rv); chk("R2 clear ignored", rv, 32'h00220000);
    extPin[2] = 1'b0; idle(6);
    rd(3'd3, rv); chk("R2 follows pin low", rv, 32'h0);
    wr(3'd0, 32'h0); idle(3);

    // R10 critical latch and acknowledge
    wr(3'd0, 32'h00000001);
    wrx(3'd7, 32'h0, 32'h0, 2'b01); idle(3);
    rd(3'd3, rv); chk("R10 crit code 1", rv, 32'h00000500);
    chk("R11 irqCrit routed", {31'b0, irqCrit}, 32'h1);
    wr(3'd3, 32'h0); idle(2);
    rd(3'd3, rv); chk("R10 ack with bit clear ignored", rv, 32'h00000500);
    // R12 ack and new pulse in same cycle
    wrx(3'd3, 32'h400, 32'h0, 2'b01); idle(2);
    rd(3'd3, rv); chk("R12 crit set beats ack", rv, 32'h00000500);
    wrx(3'd7, 32'h0, 32'h0, 2'b10); idle(2);
    wr(3'd3, 32'h400); idle(2);
    rd(3'd3, rv); chk("R10 ack clears winner only", rv, 32'h00000700);
    wr(3'd3, 32'h400); idle(2);
    rd(3'd3, rv); chk("R10 second ack", rv, 32'h0);
    chk("R11 irqCrit idle", {31'b0, irqCrit}, 32'h0);

    // R9 / R12 DMA pending set versus clear
    wrx(3'd7, 32'h0, 32'h48, 2'b0); idle(2);
    rd(3'd4, rv); chk("R9 dma pending set", rv, 32'h00000048);
    wrx(3'd4, 32'hFFFFFFFF, 32'h08, 2'b0); idle(2);
    rd(3'd4, rv); chk("R12 dma set beats clear", rv, 32'h00000008);
    wr(3'd4, 32'h00000008); idle(2);
    rd(3'd4, rv); chk("R9 dma cleared", rv, 32'h0);

    finishRun();
  end
endmodule